// File: doc/BRIEF.md
# Display General Control and Status Register Bank

This block is a byte-wide, I/O-mapped bank that holds the general control registers of a raster display adapter and returns live status from the raster timing. A host issues a 16-bit I/O address together with a write or read strobe. Writes take effect at the clock edge on which the strobe is sampled. Read data and a read-valid flag are registered and appear one cycle after the read strobe.

The control register is written at one address and read back at another. Its fields drive the sync polarity of the two sync outputs, the odd/even page select, the dot clock select code, the display-buffer decode enable and the choice between the mono and colour I/O ranges. The state of that range bit moves two items at run time: the second status register and the write port of the feature register both sit in either the 0x3Bx or the 0x3Dx range. The CRT controller range decode output moves with them.

Accesses that fall in the range not currently selected are ignored, and so are accesses to any address the bank does not decode. A write there changes nothing. A read there returns read-valid low and read data zero.

Top module: `display_gen_regs`

## Requirements
- R1: After reset the control register is 0x00 and the feature register is 0. As a result page_hi, clk_sel, buf_dec_en and crt_color are 0 and io_rvalid is 0.
- R2: A write at 0x3C2 updates the control register on that clock edge. A read at 0x3CC returns it in io_rdata with io_rvalid high in the cycle after the read strobe.
- R3: The control fields sit at these bit positions: bit 7 is the vertical polarity, bit 6 the horizontal polarity, bit 5 page_hi, bits 3:2 clk_sel, bit 1 buf_dec_en and bit 0 crt_color. Bit 4 is not stored and reads back as 0.
- R4: Each sync output equals its raw sync input when its polarity bit is 0 and is the inverse of the input when the bit is 1. The output is combinational.
- R5: clk_sel passes all four codes through unchanged, including 2'b10 and 2'b11.
- R6: When crt_color is 0 the feature register is written at 0x3BA, and when it is 1 at 0x3DA. Only data bits 1:0 are stored. A read at 0x3CA returns the stored bits in bits 1:0 with all other bits 0.
- R7: A write to the feature write address of the inactive range leaves the feature register unchanged. A read at the inactive status address (0x3DA when mono, 0x3BA when colour) gives io_rvalid 0 and io_rdata 0.
- R8: A read at 0x3C2 returns sense_in in bit 4 with all other bits 0, and it does not change the control register.
- R9: A read at the active status address (0x3BA when mono, 0x3DA when colour) returns vretrace_in in bit 3 and the inverse of disp_en_in in bit 0, with all other bits 0.
- R10: The bank decodes all 16 address bits. A read at any address it does not decode gives io_rvalid 0 and io_rdata 0, and a write there changes no register. For example, 0x13C2 is not decoded.
- R11: crt_hit is high while io_addr lies in the active CRT range (0x3B0-0x3BF when mono, 0x3D0-0x3DF when colour) and is not that range's status address (0x3BA or 0x3DA). It is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data, zero when not valid |
| io_rvalid | output | 1 | High one cycle after a read of a decoded address |
| sense_in | input | 1 | Switch-sense input |
| vretrace_in | input | 1 | Live vertical-retrace status |
| disp_en_in | input | 1 | Live display-enable status |
| hsync_in | input | 1 | Raw horizontal sync from the timing generator |
| vsync_in | input | 1 | Raw vertical sync from the timing generator |
| hsync_out | output | 1 | Horizontal sync after the polarity setting |
| vsync_out | output | 1 | Vertical sync after the polarity setting |
| page_hi | output | 1 | Odd/even page select |
| clk_sel | output | 2 | Dot clock select code |
| buf_dec_en | output | 1 | Display-buffer address decode enable |
| crt_color | output | 1 | 1 selects the colour I/O range, 0 the mono range |
| crt_hit | output | 1 | io_addr is in the active CRT controller range |

## Verification
The checker checks on every cycle that a control write shows up on the decoded outputs one cycle later, and that a sync output tracks its input at a fixed polarity whenever no control write has taken place. It also checks that reads of the inactive status address or of undecoded addresses never raise io_rvalid, that status reads keep their unused bits at zero, and that crt_hit never fires outside the two CRT ranges. The bench scenarios are needed to show the rest. These are the field positions of the read-back values, the discarded upper feature bits, and writes to the inactive feature address that leave the register unchanged. They also include switching the range at run time so that the status and feature ports move, and read-back of the external clock codes.

// File: rtl/dgr_pkg.sv
package dgr_pkg;
   localparam logic [15:0] A_MISC_WR = 16'h03C2;
   localparam logic [15:0] A_MISC_RD = 16'h03CC;
   localparam logic [15:0] A_FEAT_RD = 16'h03CA;
   localparam logic [15:0] A_STAT0   = 16'h03C2;
   localparam logic [11:0] BASE_MONO = 12'h03B;
   localparam logic [11:0] BASE_CLR  = 12'h03D;
   localparam logic [3:0]  OFS_STAT1 = 4'hA;

   typedef struct packed {
      logic       vpol;
      logic       hpol;
      logic       page;
      logic       rsv;
      logic [1:0] clk;
      logic       ram;
      logic       iosel;
   } ctrl_t;
endpackage

// File: rtl/dgr_decode.sv
module dgr_decode
   import dgr_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [AW-1:0] addr,
   input  logic          color,
   output logic          hit_ctrl_w,
   output logic          hit_ctrl_r,
   output logic          hit_feat_w,
   output logic          hit_feat_r,
   output logic          hit_stat0,
   output logic          hit_stat1,
   output logic          hit_crt
);
   localparam int HI_W = AW - 4;

   logic [HI_W-1:0] base_act;
   logic [AW-1:0]   stat1_adr;

   always_comb begin
      base_act   = color ? HI_W'(BASE_CLR) : HI_W'(BASE_MONO);
      stat1_adr  = {base_act, OFS_STAT1};
      hit_ctrl_w = (addr == AW'(A_MISC_WR));
      hit_ctrl_r = (addr == AW'(A_MISC_RD));
      hit_feat_r = (addr == AW'(A_FEAT_RD));
      hit_stat0  = (addr == AW'(A_STAT0));
      hit_stat1  = (addr == stat1_adr);
      hit_feat_w = hit_stat1;
      hit_crt    = (addr[AW-1:4] == base_act) && !hit_stat1;
   end
endmodule

// File: rtl/dgr_regs.sv
module dgr_regs
   import dgr_pkg::*;
#(
   parameter int DW     = 8,
   parameter int FEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic              feat_we,
   input  logic [DW-1:0]     wdata,
   output ctrl_t             ctrl_q,
   output logic [FEAT_W-1:0] feat_q
);
   ctrl_t wr_ctrl;

   always_comb begin
      wr_ctrl     = ctrl_t'(wdata[7:0]);
      wr_ctrl.rsv = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         feat_q <= '0;
      end else begin
         if (ctrl_we) ctrl_q <= wr_ctrl;
         if (feat_we) feat_q <= wdata[FEAT_W-1:0];
      end
   end
endmodule

// File: rtl/dgr_rdmux.sv
module dgr_rdmux
   import dgr_pkg::*;
#(
   parameter int DW     = 8,
   parameter int FEAT_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd,
   input  logic              hit_ctrl_r,
   input  logic              hit_feat_r,
   input  logic              hit_stat0,
   input  logic              hit_stat1,
   input  ctrl_t             ctrl_q,
   input  logic [FEAT_W-1:0] feat_q,
   input  logic              sense,
   input  logic              vretrace,
   input  logic              disp_en,
   output logic [DW-1:0]     rdata,
   output logic              rvalid
);
   logic [DW-1:0] rd_mux;
   logic          rd_hit;

   always_comb begin
      rd_mux = '0;
      rd_hit = 1'b1;
      if (hit_ctrl_r)      rd_mux = DW'(ctrl_q);
      else if (hit_feat_r) rd_mux = DW'(feat_q);
      else if (hit_stat0)  rd_mux = DW'({3'b000, sense, 4'b0000});
      else if (hit_stat1)  rd_mux = DW'({4'b0000, vretrace, 2'b00, ~disp_en});
      else                 rd_hit = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         rvalid <= 1'b0;
      end else begin
         rvalid <= rd && rd_hit;
         rdata  <= (rd && rd_hit) ? rd_mux : '0;
      end
   end
endmodule

// File: rtl/dgr_syncpol.sv
module dgr_syncpol #(
   parameter bit SYNC_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_in,
   input  logic vs_in,
   input  logic hpol,
   input  logic vpol,
   output logic hs_out,
   output logic vs_out
);
   logic hs_n, vs_n;

   assign hs_n = hs_in ^ hpol;
   assign vs_n = vs_in ^ vpol;

   if (SYNC_REG) begin : g_reg
      logic hs_q, vs_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
         end else begin
            hs_q <= hs_n;
            vs_q <= vs_n;
         end
      end
      assign hs_out = hs_q;
      assign vs_out = vs_q;
   end else begin : g_comb
      assign hs_out = hs_n;
      assign vs_out = vs_n;
   end
endmodule

// File: rtl/display_gen_regs.sv
module display_gen_regs
   import dgr_pkg::*;
#(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter int FEAT_W   = 2,
   parameter bit SYNC_REG = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] io_addr,
   input  logic          io_wr,
   input  logic          io_rd,
   input  logic [DW-1:0] io_wdata,
   output logic [DW-1:0] io_rdata,
   output logic          io_rvalid,
   input  logic          sense_in,
   input  logic          vretrace_in,
   input  logic          disp_en_in,
   input  logic          hsync_in,
   input  logic          vsync_in,
   output logic          hsync_out,
   output logic          vsync_out,
   output logic          page_hi,
   output logic [1:0]    clk_sel,
   output logic          buf_dec_en,
   output logic          crt_color,
   output logic          crt_hit
);
   if (DW != 8) begin : g_bad_dw
      $error("display_gen_regs: DW must be 8");
   end
   if (AW < 12) begin : g_bad_aw
      $error("display_gen_regs: AW must be at least 12");
   end
   if (FEAT_W < 1 || FEAT_W > DW) begin : g_bad_fw
      $error("display_gen_regs: FEAT_W out of range");
   end

   ctrl_t             ctrl_q;
   logic [FEAT_W-1:0] feat_q;
   logic hit_ctrl_w, hit_ctrl_r, hit_feat_w, hit_feat_r, hit_stat0, hit_stat1;

   dgr_decode #(.AW(AW)) u_dec (
      .addr(io_addr), .color(ctrl_q.iosel),
      .hit_ctrl_w(hit_ctrl_w), .hit_ctrl_r(hit_ctrl_r),
      .hit_feat_w(hit_feat_w), .hit_feat_r(hit_feat_r),
      .hit_stat0(hit_stat0), .hit_stat1(hit_stat1), .hit_crt(crt_hit)
   );

   dgr_regs #(.DW(DW), .FEAT_W(FEAT_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .ctrl_we(io_wr && hit_ctrl_w), .feat_we(io_wr && hit_feat_w),
      .wdata(io_wdata), .ctrl_q(ctrl_q), .feat_q(feat_q)
   );

   dgr_rdmux #(.DW(DW), .FEAT_W(FEAT_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(io_rd),
      .hit_ctrl_r(hit_ctrl_r), .hit_feat_r(hit_feat_r),
      .hit_stat0(hit_stat0), .hit_stat1(hit_stat1),
      .ctrl_q(ctrl_q), .feat_q(feat_q),
      .sense(sense_in), .vretrace(vretrace_in), .disp_en(disp_en_in),
      .rdata(io_rdata), .rvalid(io_rvalid)
   );

   dgr_syncpol #(.SYNC_REG(SYNC_REG)) u_sync (
      .clk(clk), .rst_n(rst_n), .hs_in(hsync_in), .vs_in(vsync_in),
      .hpol(ctrl_q.hpol), .vpol(ctrl_q.vpol),
      .hs_out(hsync_out), .vs_out(vsync_out)
   );

   assign page_hi    = ctrl_q.page;
   assign clk_sel    = ctrl_q.clk;
   assign buf_dec_en = ctrl_q.ram;
   assign crt_color  = ctrl_q.iosel;
endmodule

// File: rtl/dgr_chk.sv
module dgr_chk #(
   parameter int AW       = 16,
   parameter int DW       = 8,
   parameter bit SYNC_REG = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] io_addr,
   input logic          io_wr,
   input logic          io_rd,
   input logic [DW-1:0] io_wdata,
   input logic [DW-1:0] io_rdata,
   input logic          io_rvalid,
   input logic          hsync_in,
   input logic          hsync_out,
   input logic          vsync_in,
   input logic          vsync_out,
   input logic          page_hi,
   input logic [1:0]    clk_sel,
   input logic          buf_dec_en,
   input logic          crt_color,
   input logic          crt_hit
);
   logic ctrl_wr, inact_st, act_st, known;
   assign ctrl_wr  = io_wr && (io_addr == AW'(16'h03C2));
   assign act_st   = io_addr == (crt_color ? AW'(16'h03DA) : AW'(16'h03BA));
   assign inact_st = io_addr == (crt_color ? AW'(16'h03BA) : AW'(16'h03DA));
   assign known    = (io_addr == AW'(16'h03C2)) || (io_addr == AW'(16'h03CC)) ||
                     (io_addr == AW'(16'h03CA)) || act_st;

   // R2
   ctrl_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr |=> {page_hi, clk_sel, buf_dec_en, crt_color} ==
                  {$past(io_wdata[5]), $past(io_wdata[3:2]), $past(io_wdata[1]), $past(io_wdata[0])});

   if (!SYNC_REG) begin : g_pol
      // R4
      hsync_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(ctrl_wr) |-> ((hsync_in ^ hsync_out) == $past(hsync_in ^ hsync_out)));
      // R4
      vsync_pol_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !$past(ctrl_wr) |-> ((vsync_in ^ vsync_out) == $past(vsync_in ^ vsync_out)));
   end

   // R7
   inactive_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && inact_st && !ctrl_wr) |=> !io_rvalid && io_rdata == '0);

   // R10
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && !known) |=> !io_rvalid);

   // R9
   stat1_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && act_st && !ctrl_wr) |=> io_rvalid && io_rdata[7:4] == 4'h0 && io_rdata[2:1] == 2'b00);

   // R11
   crt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      crt_hit |-> (io_addr[AW-1:4] == (AW-4)'(12'h03B) || io_addr[AW-1:4] == (AW-4)'(12'h03D)));
endmodule

bind display_gen_regs dgr_chk #(.AW(AW), .DW(DW), .SYNC_REG(SYNC_REG)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
   .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
   .hsync_in(hsync_in), .hsync_out(hsync_out), .vsync_in(vsync_in), .vsync_out(vsync_out),
   .page_hi(page_hi), .clk_sel(clk_sel), .buf_dec_en(buf_dec_en),
   .crt_color(crt_color), .crt_hit(crt_hit)
);

// File: tb/display_gen_regs_tb.sv
module display_gen_regs_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic        io_rvalid;
   logic        sense_in = 1'b0, vretrace_in = 1'b0, disp_en_in = 1'b1;
   logic        hsync_in = 1'b0, vsync_in = 1'b0;
   logic        hsync_out, vsync_out, page_hi, buf_dec_en, crt_color, crt_hit;
   logic [1:0]  clk_sel;

   int errors = 0, checks = 0;
   logic [7:0] m_ctrl = 8'h00;
   logic [1:0] m_feat = 2'b00;
   bit         done = 1'b0;

   always #10 clk = ~clk;

   display_gen_regs u_dut (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
      .io_wdata(io_wdata), .io_rdata(io_rdata), .io_rvalid(io_rvalid),
      .sense_in(sense_in), .vretrace_in(vretrace_in), .disp_en_in(disp_en_in),
      .hsync_in(hsync_in), .vsync_in(vsync_in), .hsync_out(hsync_out), .vsync_out(vsync_out),
      .page_hi(page_hi), .clk_sel(clk_sel), .buf_dec_en(buf_dec_en),
      .crt_color(crt_color), .crt_hit(crt_hit)
   );

   task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [15:0] st1_act();
      return m_ctrl[0] ? 16'h03DA : 16'h03BA;
   endfunction

   function automatic void exp_read(input logic [15:0] a, output logic v, output logic [7:0] d);
      v = 1'b1;
      if (a == 16'h03CC)      d = m_ctrl;
      else if (a == 16'h03CA) d = {6'b0, m_feat};
      else if (a == 16'h03C2) d = {3'b0, sense_in, 4'b0};
      else if (a == st1_act()) d = {4'b0, vretrace_in, 2'b0, ~disp_en_in};
      else begin v = 1'b0; d = 8'h00; end
   endfunction

   function automatic logic exp_crt(input logic [15:0] a);
      return (a[15:4] == (m_ctrl[0] ? 12'h03D : 12'h03B)) && (a != st1_act());
   endfunction

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (a == 16'h03C2) m_ctrl = d & 8'hEF;
      else if (a == st1_act()) m_feat = d[1:0];
   endtask

   task automatic rd_chk(input logic [15:0] a, input string req);
      logic v; logic [7:0] d;
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      exp_read(a, v, d);
      #1;
      chk(crt_hit == exp_crt(a), "R11", {15'b0, crt_hit}, {15'b0, exp_crt(a)});
      @(negedge clk);
      io_rd = 1'b0;
      chk(io_rvalid == v && io_rdata == d, req, {7'b0, io_rvalid, io_rdata}, {7'b0, v, d});
   endtask

   task automatic out_chk(input string req);
      #1;
      chk({page_hi, clk_sel, buf_dec_en, crt_color} == {m_ctrl[5], m_ctrl[3:2], m_ctrl[1], m_ctrl[0]},
          req, {11'b0, page_hi, clk_sel, buf_dec_en, crt_color},
          {11'b0, m_ctrl[5], m_ctrl[3:2], m_ctrl[1], m_ctrl[0]});
      chk(hsync_out == (hsync_in ^ m_ctrl[6]) && vsync_out == (vsync_in ^ m_ctrl[7]), "R4",
          {14'b0, hsync_out, vsync_out}, {14'b0, hsync_in ^ m_ctrl[6], vsync_in ^ m_ctrl[7]});
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] alist [10];
      void'($urandom(32'h5eed_1234));
      alist = '{16'h03C2, 16'h03CC, 16'h03CA, 16'h03BA, 16'h03DA,
                16'h03B4, 16'h03D5, 16'h13C2, 16'h0000, 16'h03C0};
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(io_rvalid == 1'b0, "R1", {15'b0, io_rvalid}, 16'h0);
      out_chk("R1");
      rst_n = 1'b1;
      rd_chk(16'h03CC, "R1");
      rd_chk(16'h03CA, "R1");

      // R2 R3 directed, bit 4 dropped
      wr(16'h03C2, 8'hFF); out_chk("R3"); rd_chk(16'h03CC, "R3");
      wr(16'h03C2, 8'h24); out_chk("R2"); rd_chk(16'h03CC, "R2");
      // R5 all clock codes
      for (int c = 0; c < 4; c++) begin
         wr(16'h03C2, 8'(c << 2)); out_chk("R5"); rd_chk(16'h03CC, "R5");
      end
      // R4 polarity
      for (int p = 0; p < 4; p++) begin
         wr(16'h03C2, 8'(p << 6));
         for (int s = 0; s < 4; s++) begin
            hsync_in = s[0]; vsync_in = s[1]; out_chk("R4");
         end
      end
      // R6 R7 mono feature
      wr(16'h03C2, 8'h00);
      wr(16'h03BA, 8'hFE); rd_chk(16'h03CA, "R6");
      wr(16'h03DA, 8'h03); rd_chk(16'h03CA, "R7");
      rd_chk(16'h03DA, "R7");
      // colour
      wr(16'h03C2, 8'h01);
      wr(16'h03DA, 8'hFD); rd_chk(16'h03CA, "R6");
      wr(16'h03BA, 8'h02); rd_chk(16'h03CA, "R7");
      rd_chk(16'h03BA, "R7");
      // R8 sense
      sense_in = 1'b1; rd_chk(16'h03C2, "R8"); rd_chk(16'h03CC, "R8");
      sense_in = 1'b0; rd_chk(16'h03C2, "R8");
      // R9 status
      for (int s = 0; s < 4; s++) begin
         vretrace_in = s[0]; disp_en_in = s[1]; rd_chk(16'h03DA, "R9");
      end
      // R10 undecoded
      wr(16'h13C2, 8'hFF); out_chk("R10"); rd_chk(16'h13C2, "R10");
      wr(16'h03CC, 8'hAA); rd_chk(16'h03CC, "R10");
      rd_chk(16'h0000, "R10");

      // random mix
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         a = alist[$urandom_range(0, 9)];
         sense_in = 1'($urandom); vretrace_in = 1'($urandom); disp_en_in = 1'($urandom);
         hsync_in = 1'($urandom); vsync_in = 1'($urandom);
         if ($urandom_range(0, 1) == 0) begin
            wr(a, 8'($urandom)); out_chk("R2");
         end else begin
            rd_chk(a, (a == st1_act()) ? "R9" : "R10");
         end
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule